// File: doc/BRIEF.md
# Carrier Sense and Collision Indication Generator

This block produces the media-independent interface carrier sense (`crs`) and collision (`col`) outputs from three internal activity flags: transmit in progress, receive in progress and collision seen. Static mode inputs choose full or half duplex, loopback, repeater operation, 10 or 100 Mbps, and whether the post-transmit collision self-test pulse (heartbeat) is enabled. Both outputs are registered, so every change on an input shows at the outputs one clock later.

In half duplex, carrier sense follows receive or transmit activity. In full duplex, loopback or repeater operation it follows receive activity only. Collision is passed through in half duplex and forced low in full duplex. At 10 Mbps in half duplex with the heartbeat enabled, the end of each transmission starts a pulse on `col` whose length is a parameter in clock cycles (sized for about 1 ms). A new transmission cuts the pulse short, and so does any change of mode that no longer allows the pulse.

Top module: `crs_col_gen`

## Requirements
- R1: In half duplex with loopback and repeater off, `crs` is 1 in the cycle after a cycle in which `txActive` or `rxActive` was 1, and 0 otherwise.
- R2: When `fullDuplex`, `loopback` or `repeater` is 1, `crs` in the next cycle equals `rxActive` and ignores `txActive`.
- R3: In half duplex, `col` is 1 in the cycle after a cycle in which `colDetect` was 1.
- R4: While `fullDuplex` is 1, `col` is 0 in the following cycle, whatever `colDetect` or `txActive` do. No heartbeat pulse is produced.
- R5: In half duplex at 10 Mbps (`speed100`=0) with `hbEnable`=1, a clock edge that samples `txActive`=0 after a sampled 1 starts a heartbeat. `col` is then 1 for exactly HB_CYCLES consecutive cycles beginning right after that edge.
- R6: With `speed100`=1 or `hbEnable`=0, the end of a transmission produces no pulse on `col`.
- R7: If `txActive` is sampled 1 during a heartbeat pulse, the pulse ends: `col` is 0 from the next cycle unless a collision is also reported.
- R8: Synchronous active-high `rst` drives `crs` and `col` to 0 at the next edge and cancels any pending heartbeat.
- R9: If the mode stops allowing a heartbeat while one is running (full duplex, 100 Mbps or `hbEnable` cleared), the pulse ends at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txActive | input | 1 | Transmission in progress |
| rxActive | input | 1 | Reception in progress |
| colDetect | input | 1 | Collision condition seen on the medium |
| fullDuplex | input | 1 | 1 selects full duplex |
| loopback | input | 1 | 1 selects loopback operation |
| repeater | input | 1 | 1 selects repeater operation |
| speed100 | input | 1 | 1 selects 100 Mbps, 0 selects 10 Mbps |
| hbEnable | input | 1 | Enables the post-transmit heartbeat pulse |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision, including the heartbeat pulse |

## Verification
Carrier sense and the collision pass-through are due one clock after the inputs are sampled. The heartbeat pulse rises on the edge that first samples transmit low and lasts exactly HB_CYCLES cycles. A behavioural model in the bench advances on each rising edge with the same sampled inputs. Both outputs are compared with it at every falling edge, so each result is checked in the cycle it is due. A separate count of the pulse length confirms the heartbeat duration.

// File: rtl/cscol_pkg.sv
package cscol_pkg;
  typedef struct packed {
    logic crsUsesTx;  // transmit activity counts toward carrier
    logic colEnable;  // collision pass-through allowed
    logic hbLoad;     // start a heartbeat pulse this edge
    logic hbKill;     // clear any running heartbeat this edge
  } ctlStrobes_t;
endpackage

// File: rtl/cscol_ctrl.sv
module cscol_ctrl
  import cscol_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        txActive,
  input  logic        fullDuplex,
  input  logic        loopback,
  input  logic        repeater,
  input  logic        speed100,
  input  logic        hbEnable,
  output ctlStrobes_t strb
);
  logic txPrev;
  logic hbAllowed;

  always_ff @(posedge clk) begin
    if (rst) txPrev <= 1'b0;
    else     txPrev <= txActive;
  end

  assign hbAllowed = !fullDuplex && !speed100 && hbEnable;

  always_comb begin
    strb.crsUsesTx = !fullDuplex && !loopback && !repeater;
    strb.colEnable = !fullDuplex;
    strb.hbKill    = txActive || !hbAllowed;
    strb.hbLoad    = txPrev && !txActive && hbAllowed;
  end

  // R5: a load strobe only follows a cycle with transmit active
  assert_load_after_tx_R5: assert property (@(posedge clk) disable iff (rst)
    !txActive |=> (!strb.hbLoad || $past(txActive)) || rst);
endmodule

// File: rtl/cscol_datapath.sv
module cscol_datapath
  import cscol_pkg::*;
#(
  parameter int HB_CYCLES = 25000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        txActive,
  input  logic        rxActive,
  input  logic        colDetect,
  input  ctlStrobes_t strb,
  output logic        crs,
  output logic        col
);
  localparam int CW = $clog2(HB_CYCLES + 1);

  logic [CW-1:0] hbCount;
  logic          colDetQ;
  logic          crsQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      hbCount <= '0;
      colDetQ <= 1'b0;
      crsQ    <= 1'b0;
    end else begin
      crsQ    <= rxActive || (txActive && strb.crsUsesTx);
      colDetQ <= colDetect && strb.colEnable;
      if (strb.hbKill)           hbCount <= '0;
      else if (strb.hbLoad)      hbCount <= CW'(HB_CYCLES);
      else if (hbCount != '0)    hbCount <= hbCount - 1'b1;
    end
  end

  assign crs = crsQ;
  assign col = colDetQ || (hbCount != '0);

  assert_crs_rx_R2: assert property (@(posedge clk) disable iff (rst)
    rxActive |=> crs || rst);
  assert_crs_no_tx_R2: assert property (@(posedge clk) disable iff (rst)
    (!strb.crsUsesTx && !rxActive) |=> !crs);
  assert_crs_tx_R1: assert property (@(posedge clk) disable iff (rst)
    (strb.crsUsesTx && txActive) |=> crs || rst);
  assert_col_follow_R3: assert property (@(posedge clk) disable iff (rst)
    (strb.colEnable && colDetect) |=> col || rst);
  assert_hb_start_R5: assert property (@(posedge clk) disable iff (rst)
    (strb.hbLoad && !strb.hbKill) |=> col || rst);
  assert_hb_cut_R7: assert property (@(posedge clk) disable iff (rst)
    (strb.hbKill && !(strb.colEnable && colDetect)) |=> !col);
endmodule

// File: rtl/crs_col_gen.sv
module crs_col_gen
  import cscol_pkg::*;
#(
  parameter int HB_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst,
  input  logic txActive,
  input  logic rxActive,
  input  logic colDetect,
  input  logic fullDuplex,
  input  logic loopback,
  input  logic repeater,
  input  logic speed100,
  input  logic hbEnable,
  output logic crs,
  output logic col
);
  ctlStrobes_t strb;

  cscol_ctrl u_ctrl (
    .clk(clk), .rst(rst), .txActive(txActive), .fullDuplex(fullDuplex),
    .loopback(loopback), .repeater(repeater), .speed100(speed100),
    .hbEnable(hbEnable), .strb(strb)
  );

  cscol_datapath #(.HB_CYCLES(HB_CYCLES)) u_dp (
    .clk(clk), .rst(rst), .txActive(txActive), .rxActive(rxActive),
    .colDetect(colDetect), .strb(strb), .crs(crs), .col(col)
  );

  assert_fd_col_low_R4: assert property (@(posedge clk) disable iff (rst)
    fullDuplex |=> !col);
  assert_fast_no_hb_R6: assert property (@(posedge clk) disable iff (rst)
    (speed100 && !colDetect) |=> !col);
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!crs && !col));
endmodule

// File: tb/tb_crs_col_gen.sv
module tb_crs_col_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txActive = 0, rxActive = 0, colDetect = 0;
  logic fullDuplex = 0, loopback = 0, repeater = 0, speed100 = 0, hbEnable = 0;
  logic crs, col;

  int checks = 0;
  int errors = 0;
  string phase = "R8";

  // behavioural reference state
  int  hbLeft = 0;
  bit  prevTx = 0;
  bit  expCrs = 0, expCol = 0;
  bit  started = 0;

  crs_col_gen #(.HB_CYCLES(HB)) dut (
    .clk(clk), .rst(rst), .txActive(txActive), .rxActive(rxActive),
    .colDetect(colDetect), .fullDuplex(fullDuplex), .loopback(loopback),
    .repeater(repeater), .speed100(speed100), .hbEnable(hbEnable),
    .crs(crs), .col(col)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      hbLeft = 0; prevTx = 0; expCrs = 0; expCol = 0;
    end else begin
      if (txActive || fullDuplex || speed100 || !hbEnable) hbLeft = 0;
      else if (prevTx) hbLeft = HB;
      else if (hbLeft > 0) hbLeft = hbLeft - 1;
      if (fullDuplex || loopback || repeater) expCrs = rxActive;
      else expCrs = rxActive || txActive;
      expCol = (colDetect && !fullDuplex) || (hbLeft > 0);
      prevTx = txActive;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (crs !== expCrs || col !== expCol) begin
        errors++;
        $display("FAIL %s crs/col actual %b%b expected %b%b at %0t",
                 phase, crs, col, expCrs, expCol, $time);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic mode(input bit fd, lb, rp, sp, hb);
    fullDuplex = fd; loopback = lb; repeater = rp; speed100 = sp; hbEnable = hb;
  endtask

  task automatic txBurst(input int n);
    txActive = 1; step(n); txActive = 0;
  endtask

  initial begin
    int pulse;
    step(3);
    rst = 0;
    // R1: half duplex carrier from either direction
    phase = "R1"; mode(0,0,0,0,0);
    txBurst(3); step(2);
    rxActive = 1; step(3); rxActive = 0; step(2);
    txActive = 1; rxActive = 1; step(2); txActive = 0; rxActive = 0; step(2);
    // R2: receive only modes
    phase = "R2";
    mode(1,0,0,0,0); txBurst(3); rxActive = 1; step(2); rxActive = 0; step(2);
    mode(0,1,0,0,0); txBurst(3); step(2);
    mode(0,0,1,0,0); txBurst(3); rxActive = 1; step(2); rxActive = 0; step(2);
    // R3: collision pass-through
    phase = "R3"; mode(0,0,0,1,0);
    colDetect = 1; step(4); colDetect = 0; step(2);
    mode(0,0,0,0,0); colDetect = 1; step(1); colDetect = 0; step(3);
    // R4: full duplex blocks collision and heartbeat
    phase = "R4"; mode(1,0,0,0,1);
    colDetect = 1; txBurst(4); colDetect = 0; step(HB + 4);
    // R5: heartbeat pulse length
    phase = "R5"; mode(0,0,0,0,1);
    txBurst(5);
    pulse = 0;
    for (int i = 0; i < HB + 6; i++) begin
      step(1);
      if (col) pulse++;
    end
    checks++;
    if (pulse != HB) begin
      errors++;
      $display("FAIL R5 pulse length actual %0d expected %0d", pulse, HB);
    end
    // R6: no pulse at 100 Mbps or with heartbeat disabled
    phase = "R6";
    mode(0,0,0,1,1); txBurst(4); step(HB + 3);
    mode(0,0,0,0,0); txBurst(4); step(HB + 3);
    // R7: new transmission cuts the pulse
    phase = "R7"; mode(0,0,0,0,1);
    txBurst(3); step(5); txBurst(2); step(4);
    colDetect = 1; txBurst(2); colDetect = 0; step(HB + 3);
    // R9: mode change cuts the pulse
    phase = "R9";
    txBurst(3); step(4); mode(1,0,0,0,1); step(4); mode(0,0,0,0,1);
    txBurst(3); step(4); mode(0,0,0,1,1); step(3); mode(0,0,0,0,1);
    txBurst(3); step(4); hbEnable = 0; step(3); hbEnable = 1;
    // R8: reset during activity and pulse
    phase = "R8";
    txBurst(3); rxActive = 1; step(3); rst = 1; step(3); rst = 0; rxActive = 0;
    step(HB + 3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule